// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a segment slot number and an offset into a 32-bit linear address. It has a small set of segment slots, each backed by a hidden cache entry. In real mode the value loaded into a slot is a 16-bit paragraph number. The linear address is that value times 16 plus the low 16 bits of the offset, folded into a 20-bit space.

In protected mode a load into a slot is a selector. The unit decodes the selector, picks the global or the local descriptor table, and fetches the 8-byte descriptor through a 32-bit read port as two consecutive word reads. It keeps the base, limit, access byte and flag bits of that descriptor in the slot's cache entry. Every later translation through the slot uses only the cached copy. Each one is checked against the granularity-scaled limit, against write permission, and against a null slot. Translation results appear one cycle after the request.

While a descriptor fetch runs, the unit reports busy. Translations on the slot being loaded are held off with a stall output, and translations on other slots proceed. Paging, task switching, gates and privilege comparison are not part of this unit.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset, busy_o, mem_rd_o, ld_done_o, ld_fault_o and xl_valid_o are all 0. Every slot is in the null state, so a protected-mode access through a slot that has not been loaded reports fault code 3.
- R2: Real mode (prot_mode_i=0) works as follows.
  - A load completes in one cycle with ld_done_o and no memory read.
  - A translation returns xl_addr_o = {12'h000, (seg*16 + offset[15:0]) mod 2^20} with fault code 0, even for writes.
  - Offset bits 31:16 are ignored.
- R3: A protected-mode selector is decoded as follows.
  - The fields are index = bits 15:3, table bit = bit 2 (1 = local table at ltab_base_i, 0 = global table at gtab_base_i) and requested level = bits 1:0, which is ignored.
  - The descriptor is read at table base + index*8 and then at that address + 4, with mem_rd_o high for exactly those two cycles.
  - ld_done_o pulses in the cycle after the second read.
- R4: Descriptor layout and translation:
  - The descriptor fields are taken from word0 (at +0) and word1 (at +4) as shown below.
  - A protected translation returns base + offset (32-bit wrap).

  | Field | Bits |
  |---|---|
  | base | {word1[31:24], word1[7:0], word0[31:16]} |
  | limit | {word1[19:16], word0[15:0]} |
  | access byte | word1[15:8] |
  | granularity | word1[23] |
  | default size | word1[22] |
  | available | word1[20] |

- R5: With granularity 0 the effective limit is the 20-bit limit in bytes. With granularity 1 it is {limit, 12'hFFF}. For example, base 0x10000000 with limit 0x001FF has its last valid offset at 0x1FFFFF, which is linear address 0x101FFFFF.
- R6: busy_o is high for the two cycles of a fetch. During a fetch:
  - A translation request on the slot being loaded raises xl_stall_o and yields no result.
  - Requests on other slots are translated normally.
- R7: A selector with index 0 and table bit 0 loads at once with ld_done_o and no memory read, whatever its requested level. Every protected access through that slot then reports fault code 3.
- R8: If the fetched access byte has bit 7 (present) at 0, ld_fault_o pulses instead of ld_done_o and the slot keeps its previous cache entry.
- R9: An offset greater than the effective limit reports fault code 1. An offset equal to the limit is accepted with code 0.
- R10: A write reports fault code 2 when the access byte marks the segment executable (bit 3 = 1) or read-only data (bit 3 = 0, bit 1 = 0). Reads are unaffected. The priority is null (3), then limit (1), then write (2).
- R11: Translation uses only the cached entry. Changing descriptor memory after a load has no effect until the slot is loaded again.
- R12: A load request made while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode_i | input | 1 | 1 = protected mode, 0 = real mode |
| gtab_base_i | input | 32 | Global descriptor table base |
| ltab_base_i | input | 32 | Local descriptor table base |
| ld_valid_i | input | 1 | Segment load request |
| ld_seg_i | input | SEG_W | Slot to load |
| ld_sel_i | input | 16 | Paragraph (real) or selector (protected) |
| ld_done_o | output | 1 | Load completed, one-cycle pulse |
| ld_fault_o | output | 1 | Not-present fault on load, one-cycle pulse |
| busy_o | output | 1 | Descriptor fetch in progress |
| mem_rd_o | output | 1 | Descriptor memory read strobe |
| mem_addr_o | output | 32 | Descriptor memory byte address |
| mem_rdata_i | input | 32 | Read data, valid in the same cycle as mem_rd_o |
| xl_valid_i | input | 1 | Translation request |
| xl_seg_i | input | SEG_W | Slot used by the translation |
| xl_off_i | input | 32 | Offset |
| xl_write_i | input | 1 | 1 = write access |
| xl_stall_o | output | 1 | Request refused because its slot is loading |
| xl_valid_o | output | 1 | Translation result valid |
| xl_addr_o | output | 32 | Linear address |
| xl_fault_o | output | 2 | 0 none, 1 limit, 2 write, 3 null |

## Verification
Several properties are checked on every cycle:
- The descriptor read pair comes as exactly two strobes at consecutive word addresses, and only while busy.
- A stall is raised only while busy, and a stalled request produces no result.
- Done and fault never pulse together.
- Results follow requests, and real-mode results stay below 1 MB without faults.

Other behaviour only the bench's scenarios can show, because it depends on descriptor contents and history:
- field decoding and granularity scaling;
- fault priority;
- a slot that keeps its old entry after a not-present load or an ignored load;
- a cached entry that stays insensitive to later memory changes.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int SEL_W  = 16;
    localparam int ADDR_W = 32;
    localparam int LIM_W  = 20;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_WRITE = 2'd2,
        FLT_NULL  = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WORD0 = 2'd1,
        ST_WORD1 = 2'd2
    } fst_e;

    // hidden per-slot cache entry
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic [7:0]        acc;
        logic              gran;
        logic              dflag;
        logic              avail;
        logic              is_null;
    } seg_ent_t;

    // scatter of the two descriptor words into a cache entry
    function automatic seg_ent_t desc_unpack(input logic [31:0] w0,
                                             input logic [31:0] w1,
                                             input logic [SEL_W-1:0] sel);
        seg_ent_t e;
        e.sel     = sel;
        e.base    = {w1[31:24], w1[7:0], w0[31:16]};
        e.limit   = {w1[19:16], w0[15:0]};
        e.acc     = w1[15:8];
        e.gran    = w1[23];
        e.dflag   = w1[22];
        e.avail   = w1[20];
        e.is_null = 1'b0;
        return e;
    endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_xlat_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [ADDR_W-1:0] gbase_i,
    input  logic [ADDR_W-1:0] lbase_i,
    output logic [ADDR_W-1:0] faddr_o,
    output logic              is_null_o
);
    localparam int IDX_LSB = 3;
    localparam int IDX_W   = SEL_W - IDX_LSB;

    logic [IDX_W-1:0] idx;
    logic             tbl;
    logic [1:0]       unused_rpl;

    assign idx        = sel_i[SEL_W-1:IDX_LSB];
    assign tbl        = sel_i[2];
    assign unused_rpl = sel_i[1:0];

    assign faddr_o   = (tbl ? lbase_i : gbase_i) + (ADDR_W'(idx) << IDX_LSB);
    assign is_null_o = (idx == '0) && !tbl;
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
    import seg_xlat_pkg::*;
(
    input  seg_ent_t          ent_i,
    input  logic              prot_i,
    input  logic [ADDR_W-1:0] off_i,
    input  logic              write_i,
    output logic [ADDR_W-1:0] lin_o,
    output flt_e              flt_o
);
    localparam int PAGE_SH = ADDR_W - LIM_W;

    logic [ADDR_W-1:0] eff_lim;
    logic [19:0]       real_sum;
    logic              no_write;
    logic              unused_bits;

    assign unused_bits = ^{ent_i.acc[7:4], ent_i.acc[2], ent_i.acc[0],
                           ent_i.dflag, ent_i.avail};

    always_comb begin
        eff_lim  = ent_i.gran ? {ent_i.limit, {PAGE_SH{1'b1}}}
                              : {{PAGE_SH{1'b0}}, ent_i.limit};
        real_sum = {ent_i.sel, 4'h0} + {4'h0, off_i[15:0]};
        no_write = ent_i.acc[3] || !ent_i.acc[1];
        if (!prot_i) begin
            lin_o = {12'h000, real_sum};
            flt_o = FLT_NONE;
        end else begin
            lin_o = ent_i.base + off_i;
            if (ent_i.is_null)           flt_o = FLT_NULL;
            else if (off_i > eff_lim)    flt_o = FLT_LIMIT;
            else if (write_i && no_write) flt_o = FLT_WRITE;
            else                         flt_o = FLT_NONE;
        end
    end
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int NUM_SEGS = 4,
    localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_mode_i,
    input  logic [31:0]       gtab_base_i,
    input  logic [31:0]       ltab_base_i,
    input  logic              ld_valid_i,
    input  logic [SEG_W-1:0]  ld_seg_i,
    input  logic [15:0]       ld_sel_i,
    output logic              ld_done_o,
    output logic              ld_fault_o,
    output logic              busy_o,
    output logic              mem_rd_o,
    output logic [31:0]       mem_addr_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              xl_valid_i,
    input  logic [SEG_W-1:0]  xl_seg_i,
    input  logic [31:0]       xl_off_i,
    input  logic              xl_write_i,
    output logic              xl_stall_o,
    output logic              xl_valid_o,
    output logic [31:0]       xl_addr_o,
    output logic [1:0]        xl_fault_o
);
    localparam seg_ent_t ENT_RST = '{is_null: 1'b1, default: '0};

    typedef struct packed {
        fst_e              st;
        logic [SEG_W-1:0]  pseg;
        logic [SEL_W-1:0]  psel;
        logic [ADDR_W-1:0] faddr;
        logic [31:0]       w0;
        logic              done;
        logic              nfault;
        logic              xv;
        logic [ADDR_W-1:0] xa;
        flt_e              xf;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    seg_ent_t ent_d [NUM_SEGS];
    seg_ent_t ent_q [NUM_SEGS];

    logic [ADDR_W-1:0] dec_faddr;
    logic              dec_null;
    logic [ADDR_W-1:0] seg_lin [NUM_SEGS];
    flt_e              seg_flt [NUM_SEGS];

    seg_sel_decode u_dec (
        .sel_i     (ld_sel_i),
        .gbase_i   (gtab_base_i),
        .lbase_i   (ltab_base_i),
        .faddr_o   (dec_faddr),
        .is_null_o (dec_null)
    );

    // one checker per slot; the request slot picks the result
    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_chk
        seg_limit_check u_chk (
            .ent_i   (ent_q[s]),
            .prot_i  (prot_mode_i),
            .off_i   (xl_off_i),
            .write_i (xl_write_i),
            .lin_o   (seg_lin[s]),
            .flt_o   (seg_flt[s])
        );
    end

    always_comb begin
        seg_ent_t newent;
        ctl_d        = ctl_q;
        ent_d        = ent_q;
        ctl_d.done   = 1'b0;
        ctl_d.nfault = 1'b0;
        ctl_d.xv     = 1'b0;
        newent       = desc_unpack(ctl_q.w0, mem_rdata_i, ctl_q.psel);

        xl_stall_o = (ctl_q.st != ST_IDLE) && (xl_seg_i == ctl_q.pseg);
        if (xl_valid_i && !xl_stall_o) begin
            ctl_d.xv = 1'b1;
            ctl_d.xa = seg_lin[xl_seg_i];
            ctl_d.xf = seg_flt[xl_seg_i];
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ld_valid_i) begin
                    if (!prot_mode_i || dec_null) begin
                        ent_d[ld_seg_i]         = '0;
                        ent_d[ld_seg_i].sel     = ld_sel_i;
                        ent_d[ld_seg_i].is_null = prot_mode_i;
                        ctl_d.done              = 1'b1;
                    end else begin
                        ctl_d.st    = ST_WORD0;
                        ctl_d.pseg  = ld_seg_i;
                        ctl_d.psel  = ld_sel_i;
                        ctl_d.faddr = dec_faddr;
                    end
                end
            end
            ST_WORD0: begin
                ctl_d.w0 = mem_rdata_i;
                ctl_d.st = ST_WORD1;
            end
            ST_WORD1: begin
                if (newent.acc[7]) begin
                    ent_d[ctl_q.pseg] = newent;
                    ctl_d.done        = 1'b1;
                end else begin
                    ctl_d.nfault = 1'b1;
                end
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < NUM_SEGS; i++) ent_q[i] <= ENT_RST;
        end else begin
            ctl_q <= ctl_d;
            ent_q <= ent_d;
        end
    end

    assign busy_o     = ctl_q.st != ST_IDLE;
    assign mem_rd_o   = busy_o;
    assign mem_addr_o = (ctl_q.st == ST_WORD1) ? ctl_q.faddr + 32'd4 : ctl_q.faddr;
    assign ld_done_o  = ctl_q.done;
    assign ld_fault_o = ctl_q.nfault;
    assign xl_valid_o = ctl_q.xv;
    assign xl_addr_o  = ctl_q.xa;
    assign xl_fault_o = ctl_q.xf;
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        prot_mode_i,
    input logic        busy_o,
    input logic        mem_rd_o,
    input logic [31:0] mem_addr_o,
    input logic        xl_valid_i,
    input logic        xl_stall_o,
    input logic        xl_valid_o,
    input logic [31:0] xl_addr_o,
    input logic [1:0]  xl_fault_o,
    input logic        ld_done_o,
    input logic        ld_fault_o
);
    // R3
    rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_o) |=> mem_rd_o);
    // R3
    rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |=> !mem_rd_o);
    // R3
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 32'd4));
    // R6
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o);
    // R6
    stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_stall_o |-> busy_o);
    // R6
    stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid_i && xl_stall_o) |=> !xl_valid_o);
    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_done_o && ld_fault_o));
    // R2
    real_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid_o && !prot_mode_i) |-> (xl_addr_o[31:20] == 12'h000 && xl_fault_o == 2'd0));
    // R1
    result_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid_o |-> $past(xl_valid_i));
endmodule

bind seg_xlat_unit seg_xlat_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .prot_mode_i (prot_mode_i),
    .busy_o      (busy_o),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .xl_valid_i  (xl_valid_i),
    .xl_stall_o  (xl_stall_o),
    .xl_valid_o  (xl_valid_o),
    .xl_addr_o   (xl_addr_o),
    .xl_fault_o  (xl_fault_o),
    .ld_done_o   (ld_done_o),
    .ld_fault_o  (ld_fault_o)
);

// File: tb/seg_xlat_unit_tb_top.sv
module seg_xlat_unit_tb_top;
    localparam logic [31:0] GBASE = 32'h0000_1000;
    localparam logic [31:0] LBASE = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_mode = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic        xl_valid = 1'b0;
    logic [1:0]  xl_seg = '0;
    logic [31:0] xl_off = '0;
    logic        xl_write = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic        ld_done_o, ld_fault_o, busy_o, mem_rd_o, xl_stall_o, xl_valid_o;
    logic [31:0] mem_addr_o, xl_addr_o;
    logic [1:0]  xl_fault_o;

    always #2 clk = ~clk;   // 250 MHz

    seg_xlat_unit #(.NUM_SEGS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .prot_mode_i(prot_mode),
        .gtab_base_i(GBASE), .ltab_base_i(LBASE),
        .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_sel_i(ld_sel),
        .ld_done_o(ld_done_o), .ld_fault_o(ld_fault_o), .busy_o(busy_o),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata),
        .xl_valid_i(xl_valid), .xl_seg_i(xl_seg), .xl_off_i(xl_off),
        .xl_write_i(xl_write), .xl_stall_o(xl_stall_o), .xl_valid_o(xl_valid_o),
        .xl_addr_o(xl_addr_o), .xl_fault_o(xl_fault_o)
    );

    int checks = 0;
    int fails  = 0;
    bit run_cmp = 0;
    bit done_flag = 0;

    // descriptor memory: two 8-entry tables
    logic [31:0] gt_lo [8], gt_hi [8], lt_lo [8], lt_hi [8];
    int mem_rev = 0;

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (a >= GBASE && a < GBASE + 64) return a[2] ? gt_hi[a[5:3]] : gt_lo[a[5:3]];
        if (a >= LBASE && a < LBASE + 64) return a[2] ? lt_hi[a[5:3]] : lt_lo[a[5:3]];
        return 32'hDEAD_BEEF;
    endfunction

    always @(mem_addr_o or mem_rev) mem_rdata = mem_read(mem_addr_o);

    task automatic put_desc(input bit local_t, input int idx, input logic [31:0] base,
                            input logic [19:0] lim, input logic [7:0] acc, input logic g);
        logic [31:0] lo, hi;
        lo = {base[15:0], lim[15:0]};
        hi = {base[31:24], g, 1'b1, 1'b0, 1'b0, lim[19:16], acc, base[23:16]};
        if (local_t) begin lt_lo[idx] = lo; lt_hi[idx] = hi; end
        else         begin gt_lo[idx] = lo; gt_hi[idx] = hi; end
        mem_rev++;
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_sel [4];
    logic [31:0] m_base [4];
    logic [19:0] m_lim [4];
    logic [7:0]  m_acc [4];
    bit          m_g [4];
    bit          m_nul [4];
    int          m_busy = 0;
    int          m_pseg = 0;
    logic [15:0] m_psel = '0;
    bit          e_done = 0, e_nf = 0, e_xv = 0;
    logic [31:0] e_xa = '0;
    int          e_xf = 0;

    function automatic logic [31:0] tbl_addr(input logic [15:0] s);
        return (s[2] ? LBASE : GBASE) + 32'(s[15:3]) * 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_acc[i] = '0;
                m_g[i] = 0; m_nul[i] = 1;
            end
            m_busy = 0; e_done = 0; e_nf = 0; e_xv = 0;
        end else begin
            e_done = 0; e_nf = 0; e_xv = 0;
            if (xl_valid && !(m_busy > 0 && int'(xl_seg) == m_pseg)) begin
                logic [31:0] eff;
                e_xv = 1;
                if (!prot_mode) begin
                    e_xa = {12'h0, 20'({m_sel[xl_seg], 4'h0} + {4'h0, xl_off[15:0]})};
                    e_xf = 0;
                end else begin
                    eff  = m_g[xl_seg] ? {m_lim[xl_seg], 12'hFFF} : {12'h0, m_lim[xl_seg]};
                    e_xa = m_base[xl_seg] + xl_off;
                    if (m_nul[xl_seg]) e_xf = 3;
                    else if (xl_off > eff) e_xf = 1;
                    else if (xl_write && (m_acc[xl_seg][3] || !m_acc[xl_seg][1])) e_xf = 2;
                    else e_xf = 0;
                end
            end
            if (m_busy == 2) m_busy = 1;
            else if (m_busy == 1) begin
                logic [31:0] lo, hi;
                lo = mem_read(tbl_addr(m_psel));
                hi = mem_read(tbl_addr(m_psel) + 4);
                if (hi[15]) begin
                    m_sel[m_pseg] = m_psel; m_nul[m_pseg] = 0;
                    m_base[m_pseg] = {hi[31:24], hi[7:0], lo[31:16]};
                    m_lim[m_pseg] = {hi[19:16], lo[15:0]};
                    m_acc[m_pseg] = hi[15:8]; m_g[m_pseg] = hi[23];
                    e_done = 1;
                end else e_nf = 1;
                m_busy = 0;
            end else if (ld_valid) begin
                if (!prot_mode || (ld_sel[15:3] == 0 && !ld_sel[2])) begin
                    m_sel[ld_seg] = ld_sel; m_nul[ld_seg] = prot_mode;
                    m_base[ld_seg] = '0; m_lim[ld_seg] = '0; m_acc[ld_seg] = '0; m_g[ld_seg] = 0;
                    e_done = 1;
                end else begin
                    m_busy = 2; m_pseg = int'(ld_seg); m_psel = ld_sel;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (run_cmp) begin
            checks++;
            if (busy_o !== (m_busy > 0) || mem_rd_o !== (m_busy > 0)) begin
                fails++; $display("FAIL R6 busy/rd act=%0b/%0b exp=%0b", busy_o, mem_rd_o, m_busy > 0);
            end
            if (m_busy > 0 && mem_addr_o !== tbl_addr(m_psel) + (m_busy == 1 ? 4 : 0)) begin
                fails++; $display("FAIL R3 mem_addr act=%h exp=%h", mem_addr_o,
                                  tbl_addr(m_psel) + (m_busy == 1 ? 4 : 0));
            end
            if (ld_done_o !== e_done) begin
                fails++; $display("FAIL R3 ld_done act=%0b exp=%0b", ld_done_o, e_done);
            end
            if (ld_fault_o !== e_nf) begin
                fails++; $display("FAIL R8 ld_fault act=%0b exp=%0b", ld_fault_o, e_nf);
            end
            if (xl_stall_o !== (xl_valid ? (m_busy > 0 && int'(xl_seg) == m_pseg) : xl_stall_o)) begin
                fails++; $display("FAIL R6 stall act=%0b exp=%0b", xl_stall_o, m_busy > 0);
            end
            if (xl_valid_o !== e_xv) begin
                fails++; $display("FAIL R6 xl_valid act=%0b exp=%0b", xl_valid_o, e_xv);
            end else if (e_xv) begin
                if (xl_fault_o !== 2'(e_xf)) begin
                    fails++;
                    $display("FAIL %s fault act=%0d exp=%0d",
                             e_xf == 3 ? "R7" : e_xf == 2 ? "R10" : "R9", xl_fault_o, e_xf);
                end
                if (e_xf == 0 && xl_addr_o !== e_xa) begin
                    fails++; $display("FAIL %s addr act=%h exp=%h", prot_mode ? "R4" : "R2",
                                      xl_addr_o, e_xa);
                end
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_load(input int seg, input logic [15:0] sel,
                           output bit got_done, output bit got_flt);
        got_done = 0; got_flt = 0;
        @(posedge clk); #1; ld_valid = 1; ld_seg = 2'(seg); ld_sel = sel;
        @(posedge clk); #1; ld_valid = 0;
        repeat (4) begin
            @(negedge clk);
            if (ld_done_o) got_done = 1;
            if (ld_fault_o) got_flt = 1;
        end
    endtask

    task automatic xl_check(input int seg, input logic [31:0] off, input logic wr,
                            input logic [31:0] ea, input int ef, input string tag);
        @(posedge clk); #1; xl_valid = 1; xl_seg = 2'(seg); xl_off = off; xl_write = wr;
        @(posedge clk); #1; xl_valid = 0; xl_write = 0;
        @(negedge clk);
        checks++;
        if (!xl_valid_o || xl_fault_o != 2'(ef) || (ef == 0 && xl_addr_o != ea)) begin
            fails++;
            $display("FAIL %s seg%0d off=%h act v=%0b a=%h f=%0d exp a=%h f=%0d",
                     tag, seg, off, xl_valid_o, xl_addr_o, xl_fault_o, ea, ef);
        end
    endtask

    task automatic expect_bits(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++; $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic summary;
        if (!done_flag) begin
            done_flag = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        bit d, f;
        for (int i = 0; i < 8; i++) begin
            gt_lo[i] = '0; gt_hi[i] = '0; lt_lo[i] = '0; lt_hi[i] = '0;
        end
        put_desc(0, 1, 32'h0040_0000, 20'h00FFF, 8'h92, 0); // data rw
        put_desc(0, 2, 32'h0010_0000, 20'hFFFFF, 8'h9A, 0); // code
        put_desc(0, 3, 32'h0080_0000, 20'h00100, 8'h90, 0); // data read-only
        put_desc(0, 4, 32'h1000_0000, 20'h001FF, 8'h92, 1); // 4K granular
        put_desc(0, 5, 32'h0090_0000, 20'h00FFF, 8'h12, 0); // not present
        put_desc(1, 0, 32'h00A0_0000, 20'h00FFF, 8'h92, 0);
        put_desc(1, 3, 32'h00C0_0000, 20'h07FFF, 8'h92, 0);

        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        @(negedge clk);
        // R1 reset state
        expect_bits(busy_o | mem_rd_o | ld_done_o | ld_fault_o | xl_valid_o, 0, "R1 reset outputs");
        run_cmp = 1;

        // R2 real mode
        do_load(0, 16'h1000, d, f);
        expect_bits(d, 1, "R2 real load done");
        xl_check(0, 32'h0000_F000, 0, 32'h0001_F000, 0, "R2 real add");
        xl_check(0, 32'hABCD_1234, 1, 32'h0001_1234, 0, "R2 high offset ignored");
        do_load(1, 16'hFFFF, d, f);
        xl_check(1, 32'h0000_FFFF, 1, 32'h0000_FFEF, 0, "R2 20-bit wrap");

        @(posedge clk); #1; prot_mode = 1;
        // R1 unloaded slot in protected mode is null
        xl_check(2, 32'h0, 0, 32'h0, 3, "R1 null after reset");

        // R4 R9 R10 data segment
        do_load(0, 16'h0008, d, f);
        expect_bits(d, 1, "R3 fetch done");
        xl_check(0, 32'h10, 0, 32'h0040_0010, 0, "R4 base+off");
        xl_check(0, 32'hFFF, 1, 32'h0040_0FFF, 0, "R9 offset at limit");
        xl_check(0, 32'h1000, 0, 32'h0, 1, "R9 beyond limit");
        do_load(1, 16'h0013, d, f);
        xl_check(1, 32'h20, 0, 32'h0010_0020, 0, "R10 code read ok");
        xl_check(1, 32'h20, 1, 32'h0, 2, "R10 code write");
        do_load(2, 16'h0018, d, f);
        xl_check(2, 32'h200, 1, 32'h0, 1, "R10 limit over write priority");
        xl_check(2, 32'h50, 1, 32'h0, 2, "R10 read-only write");

        // R5 granularity
        do_load(3, 16'h0020, d, f);
        xl_check(3, 32'h001F_FFFF, 0, 32'h101F_FFFF, 0, "R5 granular end");
        xl_check(3, 32'h0020_0000, 0, 32'h0, 1, "R5 granular beyond");

        // R8 not present keeps old entry
        do_load(3, 16'h0028, d, f);
        expect_bits(f, 1, "R8 ld_fault pulse");
        expect_bits(d, 0, "R8 no done");
        xl_check(3, 32'h0000_0100, 0, 32'h1000_0100, 0, "R8 old entry retained");

        // R7 null selector
        do_load(2, 16'h0003, d, f);
        expect_bits(d, 1, "R7 null load done");
        xl_check(2, 32'h0, 0, 32'h0, 3, "R7 null access");

        // R3 local table
        do_load(0, 16'h0004, d, f);
        xl_check(0, 32'h44, 0, 32'h00A0_0044, 0, "R3 local table index 0");

        // R11 cached copy
        do_load(1, 16'h0008, d, f);
        put_desc(0, 1, 32'h0050_0000, 20'h00FFF, 8'h92, 0);
        xl_check(1, 32'h8, 0, 32'h0040_0008, 0, "R11 memory change ignored");
        do_load(1, 16'h0008, d, f);
        xl_check(1, 32'h8, 0, 32'h0050_0008, 0, "R11 reload picks up");

        // R6 stall and R12 ignored load
        @(posedge clk); #1; ld_valid = 1; ld_seg = 2'd1; ld_sel = 16'h001C;
        @(posedge clk); #1; ld_seg = 2'd2; ld_sel = 16'h0008;
        xl_valid = 1; xl_seg = 2'd1; xl_off = 32'h4;
        @(negedge clk);
        expect_bits(xl_stall_o, 1, "R6 stall on loading slot");
        @(posedge clk); #1; ld_valid = 0; xl_seg = 2'd0; xl_off = 32'h8;
        @(negedge clk);
        expect_bits(xl_stall_o, 0, "R6 other slot not stalled");
        @(posedge clk); #1; xl_valid = 0;
        @(negedge clk);
        expect_bits(xl_valid_o, 1, "R6 other slot translated while busy");
        repeat (2) @(posedge clk);
        xl_check(1, 32'h4, 0, 32'h00C0_0004, 0, "R6 load after stall");
        xl_check(2, 32'h0, 0, 32'h0, 3, "R12 load while busy ignored");

        repeat (3) @(posedge clk);
        summary();
        $finish;
    end
endmodule